// File: doc/BRIEF.md
# Paging MMU with Direct-Mapped Translation Cache

This block turns 32-bit virtual addresses into physical addresses in 4 KiB pages. The page number is split into a table index and a quarter selector. Each quarter has its own page-table base register and its own enable bit. Translated entries are kept in a direct-mapped cache, which is indexed by the low page-number bits and tagged with the rest.

A request is accepted when `req_ready` is high and `req_valid` is asserted. When the cache misses, the block reads the 32-bit page-table entry as two 16-bit physical reads on a bus-master port that uses a request/acknowledge handshake. It then stores the entry in the cache and answers. Every answer is a one-cycle `rsp_valid` pulse that carries either the physical address or a fault. When the global enable is low, addresses are passed through unchanged.

Top module: `mmu_pager`

## Requirements
- R1: With `mmu_en` low at acceptance, `rsp_addr` equals `req_addr` and `rsp_fault` is 0. No bus read is made, and `rsp_valid` rises in the cycle after acceptance.
- R2: On a cache miss in an enabled quarter, exactly two bus reads are made. The quarter is `req_addr[23:22]` and the table index is `req_addr[21:12]`. The first read, at `base[quarter] | (index << 2)`, gives entry bits 31:16. The second read, at that address plus 2, gives bits 15:0.
- R3: When entry bit 0 is 1, the physical address is entry bits 31:12 followed by `req_addr[11:0]`.
- R4: An access whose page is held in the cache makes no bus read and responds two cycles after acceptance.
- R5: A miss whose quarter enable is clear faults without any bus read.
- R6: An entry with bit 0 clear faults. That entry is still cached, so repeating the access faults with no bus read.
- R7: A bus error on either read faults and stores nothing, so the next access to the same page fetches again.
- R8: A `flush_we` pulse invalidates cache slot `flush_slot`. A later access that maps to that slot misses.
- R9: When a flush and a fill hit the same slot in the same cycle, the flush wins and the slot is left invalid.
- R10: After reset, every cache slot is invalid, every quarter is disabled, `req_ready` is 1, and `rsp_valid` and `bm_req` are 0.
- R11: The cache slot is `req_addr[21:12]` and the tag is `req_addr[31:22]`. Two pages that share a slot evict each other.
- R12: `req_ready` is low from acceptance until the response. `rsp_valid` lasts exactly one cycle, and `rsp_write` returns the request's write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmu_en | input | 1 | Global translation enable |
| cfg_we | input | 1 | Write strobe for a quarter register |
| cfg_sel | input | 2 | Quarter selected by the write |
| cfg_base | input | 32 | Page-table base written |
| cfg_en | input | 1 | Quarter enable written |
| flush_we | input | 1 | Invalidate one cache slot |
| flush_slot | input | 10 | Slot to invalidate |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | Access direction flag |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | 32 | Physical address |
| rsp_fault | output | 1 | Translation fault |
| rsp_write | output | 1 | Write flag of the answered request |
| bm_req | output | 1 | Bus-master read request |
| bm_addr | output | 32 | Physical read address |
| bm_ack | input | 1 | Read complete; data and error are valid |
| bm_rdata | input | 16 | Read data |
| bm_err | input | 1 | Read error |

## Verification
The collision that matters is an invalidate of a slot landing on the same clock edge as the refill that writes that slot at the end of a table walk. The bench's bus model raises the flush in exactly the cycle in which it acknowledges the second table read. The same page is then accessed again. If the flush took priority, this access must walk the table again with two bus reads. If the fill had taken priority, it would hit with no bus reads.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FETCH_HI,
    ST_FETCH_LO,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/mmu_qregs.sv
module mmu_qregs #(
  parameter int NQ = 4,
  parameter int AW = 32,
  localparam int QW = $clog2(NQ)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [QW-1:0]          cfg_sel,
  input  logic [AW-1:0]          cfg_base,
  input  logic                   cfg_en,
  output logic [NQ-1:0][AW-1:0]  q_base,
  output logic [NQ-1:0]          q_en
);
  for (genvar g = 0; g < NQ; g++) begin : g_quarter
    always_ff @(posedge clk) begin
      if (rst) begin
        q_base[g] <= '0;
        q_en[g]   <= 1'b0;
      end else if (cfg_we && cfg_sel == QW'(g)) begin
        q_base[g] <= cfg_base;
        q_en[g]   <= cfg_en;
      end
    end
  end
endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 10,
  parameter int FRM_W = 20,
  localparam int DEPTH = 1 << IDX_W,
  localparam int DW    = TAG_W + FRM_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_slot_v,
  output logic [TAG_W-1:0] rd_tag,
  output logic [FRM_W-1:0] rd_frame,
  output logic             rd_pv,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [FRM_W-1:0] fill_frame,
  input  logic             fill_pv,
  input  logic             flush_we,
  input  logic [IDX_W-1:0] flush_idx
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    rd_q;
  logic [DEPTH-1:0] vld;

  // Payload array: no reset, registered read, suits block RAM.
  always_ff @(posedge clk) begin
    if (fill_we) mem[fill_idx] <= {fill_tag, fill_frame, fill_pv};
    rd_q <= mem[rd_idx];
  end

  // Slot valid bits in flops so reset and flush act in one cycle.
  // The flush assignment comes last, so it wins a same-slot collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      rd_slot_v <= 1'b0;
    end else begin
      if (fill_we)  vld[fill_idx]  <= 1'b1;
      if (flush_we) vld[flush_idx] <= 1'b0;
      rd_slot_v <= vld[rd_idx];
    end
  end

  assign rd_tag   = rd_q[DW-1 -: TAG_W];
  assign rd_frame = rd_q[FRM_W:1];
  assign rd_pv    = rd_q[0];

  p_flush_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (fill_we && flush_we && fill_idx == flush_idx) |=> !vld[$past(fill_idx)]);

  p_fill_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (fill_we && !(flush_we && fill_idx == flush_idx)) |=> vld[$past(fill_idx)]);

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
    flush_we |=> !vld[$past(flush_idx)]);
endmodule

// File: rtl/mmu_walker.sv
module mmu_walker
  import mmu_pkg::*;
#(
  parameter int AW     = 32,
  parameter int OFF_W  = 12,
  parameter int NQ     = 4,
  parameter int TIDX_W = 10,
  parameter int CIDX_W = 10,
  parameter int BW     = 16,
  localparam int QW     = $clog2(NQ),
  localparam int PN_W   = AW - OFF_W,
  localparam int CTAG_W = PN_W - CIDX_W,
  localparam int FRM_W  = AW - OFF_W,
  localparam int EW     = 2 * BW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mmu_en,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         req_addr,
  input  logic                  req_write,
  output logic                  rsp_valid,
  output logic [AW-1:0]         rsp_addr,
  output logic                  rsp_fault,
  output logic                  rsp_write,
  input  logic [NQ-1:0][AW-1:0] q_base,
  input  logic [NQ-1:0]         q_en,
  output logic [CIDX_W-1:0]     t_rd_idx,
  input  logic                  t_slot_v,
  input  logic [CTAG_W-1:0]     t_tag,
  input  logic [FRM_W-1:0]      t_frame,
  input  logic                  t_pv,
  output logic                  t_fill_we,
  output logic [CIDX_W-1:0]     t_fill_idx,
  output logic [CTAG_W-1:0]     t_fill_tag,
  output logic [FRM_W-1:0]      t_fill_frame,
  output logic                  t_fill_pv,
  output logic                  bm_req,
  output logic [AW-1:0]         bm_addr,
  input  logic                  bm_ack,
  input  logic [BW-1:0]         bm_rdata,
  input  logic                  bm_err
);
  walk_st_e        st;
  logic [AW-1:0]   va_q;
  logic            wr_q;
  logic [AW-1:0]   ent_q;
  logic [BW-1:0]   hi_q;

  logic [PN_W-1:0]   page;
  logic [QW-1:0]     quarter;
  logic [TIDX_W-1:0] tidx;
  logic [AW-1:0]     ent_addr_c;
  logic [EW-1:0]     entry_c;
  logic              hit_c;

  assign page       = va_q[AW-1:OFF_W];
  assign quarter    = page[TIDX_W +: QW];
  assign tidx       = page[TIDX_W-1:0];
  assign ent_addr_c = q_base[quarter] | {{(AW-TIDX_W-2){1'b0}}, tidx, 2'b00};
  assign entry_c    = {hi_q, bm_rdata};
  assign hit_c      = t_slot_v && (t_tag == page[PN_W-1:CIDX_W]);

  assign t_rd_idx = (st == ST_IDLE) ? req_addr[OFF_W +: CIDX_W] : page[CIDX_W-1:0];

  assign t_fill_we    = (st == ST_FETCH_LO) && bm_ack && !bm_err;
  assign t_fill_idx   = page[CIDX_W-1:0];
  assign t_fill_tag   = page[PN_W-1:CIDX_W];
  assign t_fill_frame = entry_c[EW-1:OFF_W];
  assign t_fill_pv    = entry_c[0];

  assign bm_req    = (st == ST_FETCH_HI) || (st == ST_FETCH_LO);
  assign bm_addr   = (st == ST_FETCH_LO) ? ent_q + AW'(2) : ent_q;
  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_write = wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      ent_q     <= '0;
      hi_q      <= '0;
      rsp_addr  <= '0;
      rsp_fault <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q <= req_addr;
          wr_q <= req_write;
          if (!mmu_en) begin
            rsp_addr  <= req_addr;
            rsp_fault <= 1'b0;
            st        <= ST_RESP;
          end else begin
            st <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit_c) begin
            rsp_addr  <= {t_frame, va_q[OFF_W-1:0]};
            rsp_fault <= !t_pv;
            st        <= ST_RESP;
          end else if (!q_en[quarter]) begin
            rsp_addr  <= '0;
            rsp_fault <= 1'b1;
            st        <= ST_RESP;
          end else begin
            ent_q <= ent_addr_c;
            st    <= ST_FETCH_HI;
          end
        end
        ST_FETCH_HI: if (bm_ack) begin
          if (bm_err) begin
            rsp_addr  <= '0;
            rsp_fault <= 1'b1;
            st        <= ST_RESP;
          end else begin
            hi_q <= bm_rdata;
            st   <= ST_FETCH_LO;
          end
        end
        ST_FETCH_LO: if (bm_ack) begin
          rsp_addr  <= {entry_c[EW-1:OFF_W], va_q[OFF_W-1:0]};
          rsp_fault <= bm_err || !entry_c[0];
          st        <= ST_RESP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_bus_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (bm_req && !bm_ack) |=> (bm_req && $stable(bm_addr)));

  p_lo_follows_hi_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FETCH_HI && bm_ack && !bm_err) |=> (bm_req && bm_addr == $past(bm_addr) + AW'(2)));

  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_ready_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && (rsp_valid || bm_req)));

  p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && !mmu_en) |=> (rsp_valid && !rsp_fault && rsp_addr == $past(req_addr)));
endmodule

// File: rtl/mmu_pager.sv
module mmu_pager #(
  parameter int AW     = 32,
  parameter int OFF_W  = 12,
  parameter int NQ     = 4,
  parameter int TIDX_W = 10,
  parameter int CIDX_W = 10,
  parameter int BW     = 16,
  localparam int QW     = $clog2(NQ),
  localparam int PN_W   = AW - OFF_W,
  localparam int CTAG_W = PN_W - CIDX_W,
  localparam int FRM_W  = AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mmu_en,
  input  logic              cfg_we,
  input  logic [QW-1:0]     cfg_sel,
  input  logic [AW-1:0]     cfg_base,
  input  logic              cfg_en,
  input  logic              flush_we,
  input  logic [CIDX_W-1:0] flush_slot,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [AW-1:0]     rsp_addr,
  output logic              rsp_fault,
  output logic              rsp_write,
  output logic              bm_req,
  output logic [AW-1:0]     bm_addr,
  input  logic              bm_ack,
  input  logic [BW-1:0]     bm_rdata,
  input  logic              bm_err
);
  logic [NQ-1:0][AW-1:0] q_base;
  logic [NQ-1:0]         q_en;
  logic [CIDX_W-1:0]     t_rd_idx, t_fill_idx;
  logic                  t_slot_v, t_pv, t_fill_we, t_fill_pv;
  logic [CTAG_W-1:0]     t_tag, t_fill_tag;
  logic [FRM_W-1:0]      t_frame, t_fill_frame;

  mmu_qregs #(.NQ(NQ), .AW(AW)) u_qregs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_base(cfg_base), .cfg_en(cfg_en), .q_base(q_base), .q_en(q_en)
  );

  mmu_tlb #(.IDX_W(CIDX_W), .TAG_W(CTAG_W), .FRM_W(FRM_W)) u_tlb (
    .clk(clk), .rst(rst), .rd_idx(t_rd_idx), .rd_slot_v(t_slot_v),
    .rd_tag(t_tag), .rd_frame(t_frame), .rd_pv(t_pv),
    .fill_we(t_fill_we), .fill_idx(t_fill_idx), .fill_tag(t_fill_tag),
    .fill_frame(t_fill_frame), .fill_pv(t_fill_pv),
    .flush_we(flush_we), .flush_idx(flush_slot)
  );

  mmu_walker #(.AW(AW), .OFF_W(OFF_W), .NQ(NQ), .TIDX_W(TIDX_W),
               .CIDX_W(CIDX_W), .BW(BW)) u_walk (
    .clk(clk), .rst(rst), .mmu_en(mmu_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault), .rsp_write(rsp_write),
    .q_base(q_base), .q_en(q_en),
    .t_rd_idx(t_rd_idx), .t_slot_v(t_slot_v), .t_tag(t_tag),
    .t_frame(t_frame), .t_pv(t_pv),
    .t_fill_we(t_fill_we), .t_fill_idx(t_fill_idx), .t_fill_tag(t_fill_tag),
    .t_fill_frame(t_fill_frame), .t_fill_pv(t_fill_pv),
    .bm_req(bm_req), .bm_addr(bm_addr), .bm_ack(bm_ack),
    .bm_rdata(bm_rdata), .bm_err(bm_err)
  );
endmodule

// File: tb/tb_mmu_pager.sv
module tb_mmu_pager;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mmu_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_base = '0;
  logic        cfg_en = 1'b0;
  logic        flush_we;
  logic [9:0]  flush_slot;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic        rsp_write;
  logic        bm_req;
  logic [31:0] bm_addr;
  logic        bm_ack = 1'b0;
  logic [15:0] bm_rdata = '0;
  logic        bm_err = 1'b0;

  logic        flush_task = 1'b0;
  logic [9:0]  task_slot = '0;
  logic        flush_auto = 1'b0;
  logic        arm_flush = 1'b0;
  logic [9:0]  auto_slot = '0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;

  assign flush_we   = flush_task | flush_auto;
  assign flush_slot = flush_auto ? auto_slot : task_slot;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  logic [31:0] rd_log [64];
  logic [15:0] ptm [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_pager dut (
    .clk(clk), .rst(rst), .mmu_en(mmu_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_base(cfg_base), .cfg_en(cfg_en), .flush_we(flush_we), .flush_slot(flush_slot),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault), .rsp_write(rsp_write), .bm_req(bm_req),
    .bm_addr(bm_addr), .bm_ack(bm_ack), .bm_rdata(bm_rdata), .bm_err(bm_err)
  );

  // Bus responder: acknowledges each read one cycle after it is seen.
  always @(negedge clk) begin
    if (bm_req && !bm_ack) begin
      bm_ack   = 1'b1;
      bm_rdata = ptm.exists(bm_addr) ? ptm[bm_addr] : 16'h0000;
      bm_err   = (bm_addr == err_addr);
      rd_log[rd_cnt % 64] = bm_addr;
      rd_cnt++;
      flush_auto = arm_flush && bm_addr[1];
    end else begin
      bm_ack     = 1'b0;
      bm_err     = 1'b0;
      flush_auto = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_pte(input logic [31:0] a, input logic [31:0] v);
    ptm[a]          = v[31:16];
    ptm[a + 32'd2]  = v[15:0];
  endtask

  task automatic cfg_q(input logic [1:0] q, input logic [31:0] b, input logic e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = q; cfg_base = b; cfg_en = e;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_flush(input logic [9:0] s);
    @(negedge clk);
    flush_task = 1'b1; task_slot = s;
    @(negedge clk);
    flush_task = 1'b0;
  endtask

  // Issues one request; returns response fields, latency and bus reads.
  task automatic xlate(input logic [31:0] va, input logic wr,
                       output logic [31:0] pa, output logic flt,
                       output int lat, output int nrd, output int r0);
    r0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (!rsp_valid) chk(req_ready == 1'b0, "R12 ready low while busy", 32'(req_ready), 32'd0);
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    pa  = rsp_addr;
    flt = rsp_fault;
    chk(rsp_write == wr, "R12 write flag echoed", 32'(rsp_write), 32'(wr));
    nrd = rd_cnt - r0;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R12 one-cycle response then ready",
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  // {va, pa, fault, reads, first read address}
  localparam logic [99:0] VEC [9] = '{
    {32'h0000_5123, 32'hABCD_E123, 1'b0, 3'd2, 32'h0010_0014}, // R2 R3 miss
    {32'h0000_5FFF, 32'hABCD_EFFF, 1'b0, 3'd0, 32'h0},         // R4 hit
    {32'h0040_7ABC, 32'h1234_5ABC, 1'b0, 3'd2, 32'h0020_001C}, // R2 quarter 1
    {32'h0080_1000, 32'h0,         1'b1, 3'd0, 32'h0},         // R5 disabled quarter
    {32'h00C0_3FFF, 32'h0,         1'b1, 3'd2, 32'h0030_000C}, // R6 invalid entry
    {32'h00C0_3000, 32'h0,         1'b1, 3'd0, 32'h0},         // R6 cached invalid
    {32'h0040_7000, 32'h1234_5000, 1'b0, 3'd0, 32'h0},         // R4 hit
    {32'h0100_5123, 32'hABCD_E123, 1'b0, 3'd2, 32'h0010_0014}, // R11 conflict evicts
    {32'h0000_5123, 32'hABCD_E123, 1'b0, 3'd2, 32'h0010_0014}  // R11 evicted refetch
  };

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    logic [31:0] pa;
    logic        flt;
    int          lat, nrd, r0;

    set_pte(32'h0010_0014, 32'hABCD_E001);
    set_pte(32'h0020_001C, 32'h1234_5001);
    set_pte(32'h0030_000C, 32'h7777_7000);
    set_pte(32'h0010_0024, 32'h5555_5001);

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: idle state while reset is held and just after release
    chk(req_ready && !rsp_valid && !bm_req, "R10 reset outputs",
        {29'd0, req_ready, rsp_valid, bm_req}, 32'h4);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !bm_req, "R10 after release",
        {29'd0, req_ready, rsp_valid, bm_req}, 32'h4);

    // R10: quarters disabled and slots empty after reset
    mmu_en = 1'b1;
    xlate(32'h0000_5123, 1'b0, pa, flt, lat, nrd, r0);
    chk(flt == 1'b1, "R10 quarter disabled after reset", 32'(flt), 32'd1);
    chk(nrd == 0, "R10 no bus read", 32'(nrd), 32'd0);

    // R1: pass-through when disabled
    mmu_en = 1'b0;
    xlate(32'hDEAD_BEEF, 1'b1, pa, flt, lat, nrd, r0);
    chk(pa == 32'hDEAD_BEEF && !flt, "R1 passthrough address", pa, 32'hDEAD_BEEF);
    chk(nrd == 0, "R1 no bus read", 32'(nrd), 32'd0);
    chk(lat == 1, "R1 latency", 32'(lat), 32'd1);
    mmu_en = 1'b1;

    cfg_q(2'd0, 32'h0010_0000, 1'b1);
    cfg_q(2'd1, 32'h0020_0000, 1'b1);
    cfg_q(2'd2, 32'h0040_0000, 1'b0);
    cfg_q(2'd3, 32'h0030_0000, 1'b1);

    for (int i = 0; i < 9; i++) begin
      logic [31:0] e_va, e_pa, e_a0;
      logic        e_f;
      logic [2:0]  e_n;
      {e_va, e_pa, e_f, e_n, e_a0} = VEC[i];
      xlate(e_va, i[0], pa, flt, lat, nrd, r0);
      chk(flt == e_f, "R3/R5/R6 fault flag", 32'(flt), 32'(e_f));
      if (!e_f) chk(pa == e_pa, "R3 physical address", pa, e_pa);
      chk(nrd == int'(e_n), "R4/R11 bus read count", 32'(nrd), 32'(e_n));
      if (e_n == 3'd2) begin
        chk(rd_log[r0 % 64] == e_a0, "R2 high-half read address", rd_log[r0 % 64], e_a0);
        chk(rd_log[(r0 + 1) % 64] == e_a0 + 32'd2, "R2 low-half read address",
            rd_log[(r0 + 1) % 64], e_a0 + 32'd2);
      end
      if (e_n == 3'd0 && !e_f) chk(lat == 2, "R4 hit latency", 32'(lat), 32'd2);
    end

    // R7: error on the first read, then on the second, then clean
    err_addr = 32'h0010_0024;
    xlate(32'h0000_9000, 1'b0, pa, flt, lat, nrd, r0);
    chk(flt && nrd == 1, "R7 error on high read", {31'd0, flt} | (32'(nrd) << 4), 32'h11);
    err_addr = 32'h0010_0026;
    xlate(32'h0000_9000, 1'b0, pa, flt, lat, nrd, r0);
    chk(flt && nrd == 2, "R7 error on low read", {31'd0, flt} | (32'(nrd) << 4), 32'h21);
    err_addr = 32'hFFFF_FFFF;
    xlate(32'h0000_9000, 1'b0, pa, flt, lat, nrd, r0);
    chk(!flt && pa == 32'h5555_5000, "R7 clean refetch address", pa, 32'h5555_5000);
    chk(nrd == 2, "R7 nothing cached on error", 32'(nrd), 32'd2);

    // R8: flush a cached slot
    do_flush(10'd5);
    xlate(32'h0000_5000, 1'b0, pa, flt, lat, nrd, r0);
    chk(nrd == 2 && pa == 32'hABCD_E000, "R8 flushed slot misses", 32'(nrd), 32'd2);
    xlate(32'h0000_5000, 1'b0, pa, flt, lat, nrd, r0);
    chk(nrd == 0, "R8 refilled slot hits", 32'(nrd), 32'd0);

    // R9: flush and fill collide on the same slot
    do_flush(10'd7);
    auto_slot = 10'd7;
    arm_flush = 1'b1;
    xlate(32'h0040_7ABC, 1'b0, pa, flt, lat, nrd, r0);
    arm_flush = 1'b0;
    chk(!flt && pa == 32'h1234_5ABC, "R9 walk result still returned", pa, 32'h1234_5ABC);
    xlate(32'h0040_7ABC, 1'b0, pa, flt, lat, nrd, r0);
    chk(nrd == 2, "R9 flush wins over fill", 32'(nrd), 32'd2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule